// File: doc/BRIEF.md
# Synthesizer Test Output Selector with Divider Bypass

This block drives two pins of a frequency synthesizer: the main output clock `fout` and a single test pin `test_o`. A programmable M feedback divider and an N output divider normally run from the oscillator clock. The N divider sets the output rate, and the M divider output, halved by a toggle stage, is a monitor signal. A 3-bit test code picks what appears on the test pin. The choices are the serial shift-register bit, a constant high or low level, the reference clock, the halved M divider output, `fout` itself, or `fout` divided by four.

One code value puts the block in divider bypass. The slow serial clock then replaces the oscillator as the clock of both dividers. `fout` becomes the N-divided serial clock, and `test_o` carries the halved M divider output. This lets a board-level tester step the clock tree by hand while the oscillator keeps running. The default code selects the shift-register bit, so a quiet register gives a static test pin and the lowest output jitter.

Top module: `synth_test_out`

## Requirements
- R1: While `rst_n` is low, the M counter, the M toggle stage, the N counter and the divide-by-4 stage are all cleared. With `n_code` 00 this holds `fout` low, and with `t_code` 011 or 111 it holds `test_o` low.
- R2: Outside bypass, `n_code` sets the `fout` period in divider-clock cycles: 00 gives 2, 01 gives 4, 10 gives 8, and 11 gives 1, where `fout` follows the divider clock directly.
- R3: The M divider is a down-counter that reloads on terminal count, so it pulses once every M divider-clock cycles. An `m_code` of 0 counts as 1. The halved M output therefore has a period of 2×M cycles, and it appears on `test_o` when `t_code` is 011.
- R4: `t_code` 000 routes `sr_out` to `test_o`, 001 drives it high and 101 drives it low. With `t_code` 000 and `sr_out` held still, `test_o` is static.
- R5: `t_code` 010 routes `ref_clk` to `test_o`, 100 routes `fout`, and 111 routes `fout` divided by 4.
- R6: With `t_code` 110 (bypass), `ser_clk` clocks the N divider and `fout` has the R2 period counted in `ser_clk` cycles.
- R7: In bypass, `test_o` carries the halved M output clocked by `ser_clk`, with a period of 2×M `ser_clk` cycles.
- R8: In bypass, `osc_clk` has no effect: with `ser_clk` held low, `fout` and `test_o` stay constant while the oscillator runs.
- R9: New `m_code`, `n_code` and `t_code` values take effect during operation, without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, the divider clock outside bypass |
| ref_clk | input | 1 | Reference clock, observable on the test pin |
| ser_clk | input | 1 | Serial clock, the divider clock in bypass |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_out | input | 1 | Last bit of the serial shift register |
| m_code | input | 9 | M divide ratio (0 acts as 1) |
| n_code | input | 2 | N divide code (00:/2, 01:/4, 10:/8, 11:/1) |
| t_code | input | 3 | Test pin select code, 110 = bypass |
| fout | output | 1 | Main divided output clock |
| test_o | output | 1 | Test pin |

## Verification
A wrong count or reload value in the M counter changes the `test_o` period under code 011 or in bypass. This shows within two periods of the halved output, which is 2×M divider cycles. A stuck or wrong N counter tap shows as a wrong `fout` period within a few output cycles. A broken divide-by-4 stage shows as a wrong period under code 111. If the clock-source swap is wrong, `fout` keeps moving while `ser_clk` is held low in bypass, or it runs at the oscillator rate, and this shows on the next oscillator edge. A wrong test mux entry shows on `test_o` in the same cycle that its code is applied.

// File: rtl/synth_test_pkg.sv
package synth_test_pkg;
  typedef enum logic [2:0] {
    SEL_SHIFT    = 3'b000,
    SEL_HIGH     = 3'b001,
    SEL_REF      = 3'b010,
    SEL_MHALF    = 3'b011,
    SEL_FOUT     = 3'b100,
    SEL_LOW      = 3'b101,
    SEL_BYPASS   = 3'b110,
    SEL_FQUARTER = 3'b111
  } tsel_e;

  typedef enum logic [1:0] {
    NDIV_2 = 2'b00,
    NDIV_4 = 2'b01,
    NDIV_8 = 2'b10,
    NDIV_1 = 2'b11
  } ndiv_e;
endpackage

// File: rtl/synth_m_divider.sv
module synth_m_divider #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  output logic           half
);
  logic [M_W-1:0] cnt;
  logic [M_W-1:0] eff;
  logic           tc;

  // A ratio of zero behaves as a ratio of one
  always_comb eff = (m_val == '0) ? M_W'(1) : m_val;

  assign tc = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (tc) cnt <= eff - M_W'(1);
    else         cnt <= cnt - M_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  half <= 1'b0;
    else if (tc) half <= ~half;
  end
endmodule

// File: rtl/synth_n_divider.sv
module synth_n_divider
  import synth_test_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] n_val,
  output logic       out
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q + STAGES'(1);
  end

  always_comb begin
    case (ndiv_e'(n_val))
      NDIV_2:  out = q[0];
      NDIV_4:  out = q[1];
      NDIV_8:  out = q[2];
      default: out = clk;
    endcase
  end
endmodule

// File: rtl/synth_mon_div.sv
module synth_mon_div #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic out
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q + STAGES'(1);
  end

  assign out = q[STAGES-1];
endmodule

// File: rtl/synth_test_mux.sv
module synth_test_mux
  import synth_test_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       sr_bit,
  input  logic       ref_in,
  input  logic       m_half,
  input  logic       fout_in,
  input  logic       fout_q,
  output logic       pin
);
  always_comb begin
    case (tsel_e'(sel))
      SEL_SHIFT:    pin = sr_bit;
      SEL_HIGH:     pin = 1'b1;
      SEL_REF:      pin = ref_in;
      SEL_MHALF:    pin = m_half;
      SEL_FOUT:     pin = fout_in;
      SEL_LOW:      pin = 1'b0;
      SEL_BYPASS:   pin = m_half;
      default:      pin = fout_q;
    endcase
  end
endmodule

// File: rtl/synth_test_out.sv
module synth_test_out
  import synth_test_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int N_STAGES = 3,
  parameter int Q_STAGES = 2
) (
  input  logic           osc_clk,
  input  logic           ref_clk,
  input  logic           ser_clk,
  input  logic           rst_n,
  input  logic           sr_out,
  input  logic [M_W-1:0] m_code,
  input  logic [1:0]     n_code,
  input  logic [2:0]     t_code,
  output logic           fout,
  output logic           test_o
);
  logic bypass;
  logic div_clk;
  logic m_half;
  logic fout_q;

  assign bypass  = (t_code == SEL_BYPASS);
  // Divider clock source swap
  assign div_clk = bypass ? ser_clk : osc_clk;

  synth_m_divider #(.M_W(M_W)) u_mdiv (
    .clk   (div_clk),
    .rst_n (rst_n),
    .m_val (m_code),
    .half  (m_half)
  );

  synth_n_divider #(.STAGES(N_STAGES)) u_ndiv (
    .clk   (div_clk),
    .rst_n (rst_n),
    .n_val (n_code),
    .out   (fout)
  );

  synth_mon_div #(.STAGES(Q_STAGES)) u_quarter (
    .clk   (fout),
    .rst_n (rst_n),
    .out   (fout_q)
  );

  synth_test_mux u_mux (
    .sel     (t_code),
    .sr_bit  (sr_out),
    .ref_in  (ref_clk),
    .m_half  (m_half),
    .fout_in (fout),
    .fout_q  (fout_q),
    .pin     (test_o)
  );
endmodule

// File: rtl/synth_test_out_chk.sv
module synth_test_out_chk #(
  parameter int M_W = 9
) (
  input logic           osc_clk,
  input logic           ref_clk,
  input logic           ser_clk,
  input logic           rst_n,
  input logic           sr_out,
  input logic [M_W-1:0] m_code,
  input logic [1:0]     n_code,
  input logic [2:0]     t_code,
  input logic           fout,
  input logic           test_o
);
  assert_sr_follow_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (t_code == 3'b000) |-> (test_o == sr_out));

  assert_static_high_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (t_code == 3'b001) |-> test_o);

  assert_static_low_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (t_code == 3'b101) |-> !test_o);

  assert_ref_route_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (t_code == 3'b010) |-> (test_o == ref_clk));

  assert_fout_route_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (t_code == 3'b100) |-> (test_o == fout));

  assert_pass_n1_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (t_code != 3'b110 && n_code == 2'b11) |-> (fout == osc_clk));

  assert_half_rate_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    ($past(rst_n) && t_code != 3'b110 && $stable(t_code) &&
     n_code == 2'b00 && $stable(n_code)) |-> (fout != $past(fout)));

  assert_bypass_hold_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
    ($past(rst_n) && t_code == 3'b110 && $stable(t_code) && !ser_clk &&
     !$past(ser_clk) && $stable(m_code) && $stable(n_code))
    |-> ($stable(fout) && $stable(test_o)));
endmodule

bind synth_test_out synth_test_out_chk #(.M_W(M_W)) u_chk (
  .osc_clk (osc_clk),
  .ref_clk (ref_clk),
  .ser_clk (ser_clk),
  .rst_n   (rst_n),
  .sr_out  (sr_out),
  .m_code  (m_code),
  .n_code  (n_code),
  .t_code  (t_code),
  .fout    (fout),
  .test_o  (test_o)
);

// File: tb/synth_test_out_tb.sv
`timescale 1ns/1ps
module synth_test_out_tb;
  logic       osc_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_run = 1'b0;
  logic       rst_n   = 1'b0;
  logic       sr_out  = 1'b0;
  logic [8:0] m_code  = 9'd5;
  logic [1:0] n_code  = 2'b00;
  logic [2:0] t_code  = 3'b000;
  logic       fout;
  logic       test_o;
  int         checks = 0;
  int         errors = 0;

  always #5 osc_clk = ~osc_clk;   // 100 MHz
  always #7 ref_clk = ~ref_clk;   // 14 ns period
  always begin
    if (ser_run) begin
      #15 ser_clk = ~ser_clk;     // 30 ns period
    end else begin
      ser_clk = 1'b0;
      #1;
    end
  end

  synth_test_out u_dut (
    .osc_clk (osc_clk),
    .ref_clk (ref_clk),
    .ser_clk (ser_clk),
    .rst_n   (rst_n),
    .sr_out  (sr_out),
    .m_code  (m_code),
    .n_code  (n_code),
    .t_code  (t_code),
    .fout    (fout),
    .test_o  (test_o)
  );

  typedef struct packed {
    logic [2:0] t;
    logic [8:0] m;
    logic [1:0] n;
    int         fper;
    int         tper;   // 0: test pin static
    logic       tlev;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 9'd5,   2'b00, 20, 0,     1'b0},  // R2 /2, R4 shift bit
    '{3'b001, 9'd5,   2'b01, 40, 0,     1'b1},  // R2 /4, R4 high
    '{3'b010, 9'd5,   2'b10, 80, 14,    1'b0},  // R2 /8, R5 ref
    '{3'b011, 9'd5,   2'b11, 10, 100,   1'b0},  // R2 /1, R3 M=5
    '{3'b100, 9'd7,   2'b01, 40, 40,    1'b0},  // R5 fout, R9
    '{3'b101, 9'd7,   2'b00, 20, 0,     1'b0},  // R4 low
    '{3'b111, 9'd7,   2'b00, 20, 80,    1'b0},  // R5 fout/4
    '{3'b011, 9'd0,   2'b10, 80, 20,    1'b0},  // R3 M=0 as 1
    '{3'b011, 9'd1,   2'b00, 20, 20,    1'b0},  // R3 M=1
    '{3'b011, 9'd511, 2'b01, 40, 10220, 1'b0}   // R3 largest M
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rise(input bit on_test);
    if (on_test) @(posedge test_o);
    else         @(posedge fout);
  endtask

  task automatic period(input bit on_test, output int per);
    realtime t0, t1;
    rise(on_test);
    rise(on_test);
    rise(on_test);
    t0 = $realtime;
    rise(on_test);
    t1 = $realtime;
    per = $rtoi(t1 - t0 + 0.5);
  endtask

  task automatic still(input string req, input string what, input logic lev);
    int bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge osc_clk);
      if (test_o !== lev) bad++;
    end
    chk(req, what, bad, 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per;
    string tag;
    // R1: reset state
    repeat (5) @(negedge osc_clk);
    chk("R1", "fout in reset", int'(fout), 0);
    chk("R1", "test shift bit in reset", int'(test_o), 0);
    t_code = 3'b011;
    @(negedge osc_clk);
    chk("R1", "M half in reset", int'(test_o), 0);
    t_code = 3'b111;
    @(negedge osc_clk);
    chk("R1", "fout/4 in reset", int'(test_o), 0);
    t_code = 3'b000;
    @(negedge osc_clk);
    rst_n = 1'b1;

    // Vector walk, no reset between entries (R9)
    for (int i = 0; i < NV; i++) begin
      @(negedge osc_clk);
      t_code = VECS[i].t;
      m_code = VECS[i].m;
      n_code = VECS[i].n;
      repeat (3) @(negedge osc_clk);
      period(1'b0, per);
      chk("R2", $sformatf("fout period vec %0d", i), per, VECS[i].fper);
      if (VECS[i].t == 3'b011)      tag = "R3";
      else if (VECS[i].tper == 0)   tag = "R4";
      else                          tag = "R5";
      if (VECS[i].tper == 0) begin
        still(tag, $sformatf("static test vec %0d", i), VECS[i].tlev);
      end else begin
        period(1'b1, per);
        chk(tag, $sformatf("test period vec %0d", i), per, VECS[i].tper);
      end
    end

    // R4: test pin follows the shift bit
    t_code = 3'b000;
    sr_out = 1'b1;
    @(negedge osc_clk);
    chk("R4", "shift bit high", int'(test_o), 1);
    sr_out = 1'b0;
    @(negedge osc_clk);
    chk("R4", "shift bit low", int'(test_o), 0);

    // R6/R7: bypass with the serial clock
    m_code  = 9'd3;
    n_code  = 2'b01;
    t_code  = 3'b110;
    ser_run = 1'b1;
    period(1'b0, per);
    chk("R6", "bypass fout /4", per, 120);
    period(1'b1, per);
    chk("R7", "bypass test 2xM", per, 180);
    n_code = 2'b11;
    repeat (10) @(negedge osc_clk);
    period(1'b0, per);
    chk("R6", "bypass fout /1", per, 30);

    // R8: oscillator ignored in bypass
    n_code = 2'b00;
    repeat (10) @(negedge osc_clk);
    ser_run = 1'b0;
    repeat (3) @(negedge osc_clk);
    begin
      logic f0, t0v;
      int moved = 0;
      f0  = fout;
      t0v = test_o;
      for (int i = 0; i < 40; i++) begin
        @(negedge osc_clk);
        if (fout !== f0 || test_o !== t0v) moved++;
      end
      chk("R8", "outputs move without serial clock", moved, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule